// File: doc/BRIEF.md
# Exponential-Average Idle Period Predictor

This block watches a single activity line and splits time into alternating busy and idle stretches, counting each stretch in clock cycles. It keeps a running estimate of how long the next idle stretch will last. After every idle stretch the estimate is refreshed as a weighted mix of the stretch just measured and the old estimate. The weight is a fraction in steps of 1/16.

On the first cycle of each idle stretch the block decides whether to request a shutdown straight away, without waiting for a timeout. The decision takes one of two forms, selected by a mode input. In estimate mode it compares the running estimate with a break-even length. In threshold mode it requests shutdown when the busy stretch just ended was short. Every return to activity raises a wake request. When predictive wakeup is enabled and a shutdown was requested, the block also raises a wake request on its own once the idle stretch reaches the estimated length. The power-state sequencing that acts on these requests lives outside the block.

Top module: `idle_predictor`

## Requirements
- R1: When a busy cycle follows an idle cycle, the estimate on `pred_o` becomes floor((w·L + (16−w)·P)/16) on the next cycle. Here L is the measured idle length, P is the old estimate, and w is `alpha_i` clamped to 16. At all other times `pred_o` holds its value.
- R2: In estimate mode (`thr_mode_i`=0), `shutdown_req_o` is high for exactly one cycle, the cycle after the first idle cycle of a stretch, if and only if the estimate then exceeds `break_even_i`.
- R3: In threshold mode (`thr_mode_i`=1), that one-cycle shutdown pulse appears if and only if the preceding busy length is below `act_thresh_i`. The busy length is the count of consecutive busy cycles, and is 0 if no busy cycle has been seen since reset.
- R4: With `wake_pred_en_i`=1 and a shutdown requested for the current stretch, `wake_req_o` pulses for one cycle, the cycle after the idle cycle in which the idle length (1 on the first idle cycle) equals the estimate. This happens at most once per stretch.
- R5: The first busy cycle after an idle cycle always gives a one-cycle `wake_req_o` pulse on the next cycle, whatever the mode or the estimate.
- R6: The idle and busy length counts saturate at 2^CW−1 and never wrap.
- R7: After reset, both request outputs and the estimate are 0, and the line is treated as having been busy. As a result, estimate mode requests no shutdown until one idle stretch has been measured.
- R8: With `wake_pred_en_i`=0, `wake_req_o` rises only as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | 1 = active cycle, 0 = idle cycle |
| thr_mode_i | input | 1 | 0 = estimate mode, 1 = threshold mode |
| wake_pred_en_i | input | 1 | Enables wakeup on expiry of the estimate |
| alpha_i | input | 5 | Update weight in 1/16 steps, values above 16 treated as 16 |
| break_even_i | input | CW | Break-even idle length in cycles |
| act_thresh_i | input | CW | Busy-length limit for threshold mode |
| shutdown_req_o | output | 1 | One-cycle shutdown request |
| wake_req_o | output | 1 | One-cycle wake request |
| pred_o | output | CW | Current idle length estimate |

## Verification
The assertions assume that `busy_i` is a clean synchronous level and that the mode, weight, break-even and threshold inputs do not change between the first idle cycle of a stretch and the decision they feed. The bench drives every input on the falling edge and changes settings only between stretches, so each decision sees settled values. Stretch lengths run from one cycle up past the saturation point of a narrowed counter, so single-cycle idle stretches, an estimate of 1, and clamped weights are all covered.

// File: rtl/idp_pkg.sv
package idp_pkg;
    localparam int WSH = 4;               // fraction bits of the weight
    localparam int ONE = 1 << WSH;        // weight meaning 1.0
    localparam int AW  = WSH + 1;         // weight port width

    typedef struct packed {
        logic busy;
        logic armed;
        logic sd;
        logic wk;
    } ctl_t;
endpackage

// File: rtl/idp_len_counter.sv
module idp_len_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_d_o,
    output logic [CW-1:0] cnt_q_o
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(1);
        else if (inc_i && cnt_q != MAXV)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_d_o = cnt_d;
    assign cnt_q_o = cnt_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && inc_i && !start_i) |=> cnt_q == MAXV); // R6
endmodule

// File: rtl/idp_ewma.sv
module idp_ewma
    import idp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [AW-1:0] alpha_i,
    input  logic [CW-1:0] sample_i,
    input  logic [CW-1:0] prev_i,
    output logic [CW-1:0] next_o
);
    localparam int PW = CW + WSH + 1;

    logic [AW-1:0] w, wc;
    logic [PW-1:0] sum;

    always_comb begin
        w   = (alpha_i > AW'(ONE)) ? AW'(ONE) : alpha_i;
        wc  = AW'(ONE) - w;
        sum = PW'(w) * PW'(sample_i) + PW'(wc) * PW'(prev_i);
        next_o = CW'(sum >> WSH);
    end
endmodule

// File: rtl/idle_predictor.sv
module idle_predictor
    import idp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          thr_mode_i,
    input  logic          wake_pred_en_i,
    input  logic [4:0]    alpha_i,
    input  logic [CW-1:0] break_even_i,
    input  logic [CW-1:0] act_thresh_i,
    output logic          shutdown_req_o,
    output logic          wake_req_o,
    output logic [CW-1:0] pred_o
);
    ctl_t          ctl_d, ctl_q;
    logic [CW-1:0] pred_d, pred_q, pred_upd;
    logic [CW-1:0] idle_d, idle_q, act_d, act_q;
    logic          idle_start, idle_end, decide, arm_now, fire;

    assign idle_start = !busy_i && ctl_q.busy;
    assign idle_end   = busy_i && !ctl_q.busy;

    idp_len_counter #(.CW(CW)) u_idle (
        .clk(clk), .rst_n(rst_n), .start_i(idle_start), .inc_i(!busy_i),
        .cnt_d_o(idle_d), .cnt_q_o(idle_q));

    idp_len_counter #(.CW(CW)) u_act (
        .clk(clk), .rst_n(rst_n), .start_i(idle_end), .inc_i(busy_i),
        .cnt_d_o(act_d), .cnt_q_o(act_q));

    idp_ewma #(.CW(CW)) u_ewma (
        .alpha_i(alpha_i), .sample_i(idle_q), .prev_i(pred_q), .next_o(pred_upd));

    always_comb begin
        decide  = thr_mode_i ? (act_q < act_thresh_i) : (pred_q > break_even_i);
        arm_now = idle_start && decide && wake_pred_en_i;
        fire    = !busy_i && (ctl_q.armed || arm_now) && (idle_d == pred_q);

        ctl_d.busy  = busy_i;
        ctl_d.sd    = idle_start && decide;
        ctl_d.wk    = idle_end || fire;
        ctl_d.armed = (ctl_q.armed || arm_now) && !busy_i && !fire;
        pred_d      = idle_end ? pred_upd : pred_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '{busy: 1'b1, armed: 1'b0, sd: 1'b0, wk: 1'b0};
            pred_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            pred_q <= pred_d;
        end
    end

    assign shutdown_req_o = ctl_q.sd;
    assign wake_req_o     = ctl_q.wk;
    assign pred_o         = pred_q;

    AST_PRED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_i && !ctl_q.busy) |=> $stable(pred_o)); // R1
    AST_SHDN_EST: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_req_o && !$past(thr_mode_i)) |-> $past(pred_o) > $past(break_even_i)); // R2
    AST_SHDN_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_req_o && $past(thr_mode_i)) |-> $past(act_q) < $past(act_thresh_i)); // R3
    AST_SHDN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req_o |-> ($past(!busy_i) && !ctl_q.busy)); // R2
    AST_WAKE_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !ctl_q.busy) |=> wake_req_o); // R5
    AST_WAKE_PRED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_o && !$past(busy_i)) |-> $past(wake_pred_en_i)); // R8
endmodule

// File: tb/sim_idle_predictor.sv
module sim_idle_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 10;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 0, rst_n = 0;
    logic          busy = 1, mode = 0, wen = 0;
    logic [4:0]    alpha = 8;
    logic [CW-1:0] be = 5, thr = 8;
    logic          sd, wk;
    logic [CW-1:0] pred;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string cur_req = "R7";
    bit live = 0;

    // behavioural reference state
    int m_bprev = 1, m_act = 0, m_idle = 0, m_pred = 0, m_arm = 0;
    int m_sd = 0, m_wk = 0;

    idle_predictor #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .thr_mode_i(mode),
        .wake_pred_en_i(wen), .alpha_i(alpha), .break_even_i(be),
        .act_thresh_i(thr), .shutdown_req_o(sd), .wake_req_o(wk), .pred_o(pred));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            int w;
            bit st, en;
            w  = (alpha > 16) ? 16 : alpha;
            st = !busy && m_bprev == 1;
            en = busy && m_bprev == 0;
            m_sd = 0; m_wk = 0;
            if (st) begin
                m_sd  = mode ? (m_act < thr) : (m_pred > be);
                m_arm = m_sd && wen;
                m_idle = 1;
            end else if (!busy) begin
                m_idle = (m_idle < MAXV) ? m_idle + 1 : MAXV;
            end
            if (en) begin
                m_wk   = 1;
                m_pred = (w * m_idle + (16 - w) * m_pred) / 16;
                m_arm  = 0;
                m_act  = 1;
            end else if (busy) begin
                m_act = (m_act < MAXV) ? m_act + 1 : MAXV;
            end
            if (!busy && m_arm && m_idle == m_pred) begin
                m_wk = 1; m_arm = 0;
            end
            m_bprev = busy;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (live) begin
            check(cur_req, "shutdown_req", sd, m_sd);
            check(cur_req, "wake_req", wk, m_wk);
            check(cur_req, "pred", pred, m_pred);
        end
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run(bit b, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            busy = b;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7", "reset shutdown_req", sd, 0);
        check("R7", "reset wake_req", wk, 0);
        check("R7", "reset pred", pred, 0);
        rst_n = 1;
        live = 1;
        // R7: first idle in estimate mode must not request shutdown
        cur_req = "R7"; mode = 0; be = 0; run(1, 3); run(0, 6);
        // R1 and R2: build an estimate and compare with break-even
        cur_req = "R1"; be = 5; alpha = 8; run(1, 4); run(0, 20); run(1, 10);
        cur_req = "R2"; run(0, 20); run(1, 5);
        alpha = 16; run(0, 3); run(1, 5);
        run(0, 8); run(1, 4);
        // R4: predictive wakeup at the estimate
        cur_req = "R4"; wen = 1; alpha = 16; be = 2; run(0, 12); run(1, 6);
        run(0, 30); run(1, 6);
        be = 0; run(0, 1); run(1, 3); run(0, 5); run(1, 3);
        // R8: no predictive wakeup when disabled
        cur_req = "R8"; wen = 0; alpha = 0; run(0, 30); run(1, 5);
        // R3: threshold mode
        cur_req = "R3"; mode = 1; thr = 8; wen = 1; run(1, 5); run(0, 9);
        run(1, 20); run(0, 9); run(1, 7); run(0, 4); run(1, 8); run(0, 4);
        // R1: weight clamp above 16
        cur_req = "R1"; mode = 0; alpha = 20; run(1, 3); run(0, 7); run(1, 3);
        alpha = 5; run(0, 40); run(1, 3);
        // R5: single-cycle idle stretches
        cur_req = "R5"; for (int i = 0; i < 6; i++) begin run(0, 1); run(1, 1); end
        // R6: saturation of both counts
        cur_req = "R6"; alpha = 16; mode = 1; thr = MAXV; run(1, 1100); run(0, 1100);
        run(1, 3);
        @(negedge clk); #1;
        check("R6", "saturated pred", pred, MAXV);
        // mixed random stretches
        cur_req = "R2";
        for (int k = 0; k < 300; k++) begin
            mode  = $urandom_range(0, 1);
            wen   = $urandom_range(0, 1);
            alpha = 5'($urandom_range(0, 20));
            be    = CW'($urandom_range(0, 30));
            thr   = CW'($urandom_range(0, 30));
            cur_req = mode ? "R3" : (wen ? "R4" : "R2");
            run(1, $urandom_range(1, 40));
            run(0, $urandom_range(1, 40));
        end
        run(1, 5);
        live = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule